// File: doc/BRIEF.md
# Multiplexed Joypad Matrix Register

This block is a single memory-mapped input register for an eight-button pad. The buttons form two groups of four: an action group (Start, Select, B, A) and a direction group (Down, Up, Left, Right). Software writes two active-low select bits to choose which group or groups it wants to see. A read returns the pressed buttons of the chosen groups as zeros in the low nibble.

When neither group is selected, the low nibble carries a multiplayer identifier instead. That identifier is 0xF minus the request value supplied on an input. Unless a permissive mode input is set, the block never reports opposing directions together. A held Up hides Down, and a held Left hides Right.

A one-cycle interrupt pulse marks each moment the low nibble leaves 0xF. Holding a button does not retrigger it.

Top module: `joy_matrix_reg`

## Requirements
- R1: After reset both select bits are 1. With a multiplayer request of 0, a read returns 0xFF, and the interrupt output is 0.
- R2: A write (cs_i and we_i high at a clock edge) stores wdata_i bit 5 and bit 4 as the two select bits. Every read returns 1 in bits 7 and 6, select bit 5 in bit 5 and select bit 4 in bit 4, and this reflects the write from the next cycle on.
- R3: With select bit 5 at 0, the low nibble is ANDed with the inverted action group. The action group is Start in bit 3, Select in bit 2, B in bit 1 and A in bit 0, taken from act_i bits 3..0.
- R4: With select bit 4 at 0, the low nibble is ANDed with the inverted direction group. The direction group is Down in bit 3, Up in bit 2, Left in bit 1 and Right in bit 0, taken from dir_i bits 3..0.
- R5: With both select bits at 0, both inverted groups are ANDed together into the nibble.
- R6: With both select bits at 1, the low nibble is 0xF minus mp_id_i (modulo 16), and the buttons have no effect on it.
- R7: With allow_opp_i at 0, a pressed Up (dir_i[2]) suppresses Down (dir_i[3]), and a pressed Left (dir_i[1]) suppresses Right (dir_i[0]).
- R8: With allow_opp_i at 1, opposing directions are reported together as pressed.
- R9: irq_o is high for exactly one cycle, in the cycle after a clock edge at which the nibble went from 0xF to something else. It stays low while the nibble stays off 0xF.
- R10: A cycle with we_i high but cs_i low leaves the select bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| act_i | input | 4 | Action buttons, active high (Start, Select, B, A in bits 3..0) |
| dir_i | input | 4 | Direction buttons, active high (Down, Up, Left, Right in bits 3..0) |
| mp_id_i | input | 4 | Multiplayer request value |
| allow_opp_i | input | 1 | 1 lets opposing directions show together |
| cs_i | input | 1 | Register select |
| we_i | input | 1 | Write strobe, qualified by cs_i |
| wdata_i | input | 8 | Write data; bits 5 and 4 are used |
| rdata_o | output | 8 | Read data: 11, selects, nibble |
| irq_o | output | 1 | One-cycle interrupt request pulse |

## Verification
The hardest case to reach is the interrupt edge rule. A pulse must appear once when the nibble leaves 0xF and never again while it stays away. The nibble can also leave 0xF through a select write or a multiplayer value rather than a button press. The bench first parks the nibble at 0xF by selecting the action group with nothing pressed. It then presses a button, holds it across several cycles, and releases and presses again. Every cycle, it checks that the pulse appears exactly once per departure. Opposing-direction masking is reached by driving all four directions with the mode input at both values.

// File: rtl/joy_pkg.sv
// Shared types for the joypad matrix register.
// Assumes a four-line group width; the select encoding is active low.
package joy_pkg;
    localparam int GRP_W = 4;
    typedef logic [GRP_W-1:0] grp_t;
    localparam grp_t IDLE_NIB = '1;
endpackage

// File: rtl/joy_dir_filter.sv
// Opposing-direction filter. Assumes the bit order Down=3, Up=2, Left=1, Right=0.
// Up wins over Down and Left wins over Right unless allow_i is set.
module joy_dir_filter
    import joy_pkg::*;
(
    input  grp_t dir_i,
    input  logic allow_i,
    output grp_t dir_o
);
    // Purpose: clear the losing line of each opposing pair.
    always_comb begin
        dir_o = dir_i;
        if (!allow_i) begin
            if (dir_i[2]) dir_o[3] = 1'b0;
            if (dir_i[1]) dir_o[0] = 1'b0;
        end
    end
endmodule

// File: rtl/joy_nibble.sv
// Low-nibble builder. Starts from all ones, subtracts the multiplayer value
// when both selects are high, then masks in each selected group inverted.
module joy_nibble
    import joy_pkg::*;
(
    input  logic       sel_act_n,
    input  logic       sel_dir_n,
    input  grp_t       act_i,
    input  grp_t       dir_i,
    input  grp_t       mp_i,
    output grp_t       nib_o
);
    grp_t groups [2];
    logic sel_n [2];
    grp_t masked [2];

    assign groups[0] = act_i;
    assign groups[1] = dir_i;
    assign sel_n[0]  = sel_act_n;
    assign sel_n[1]  = sel_dir_n;

    // Purpose: one mask per group, all ones when the group is deselected.
    for (genvar g = 0; g < 2; g++) begin : g_grp
        assign masked[g] = sel_n[g] ? IDLE_NIB : ~groups[g];
    end

    // Purpose: combine the base value with both group masks.
    always_comb begin
        grp_t base;
        base = IDLE_NIB;
        if (sel_act_n && sel_dir_n) base = IDLE_NIB - mp_i;
        nib_o = base & masked[0] & masked[1];
    end
endmodule

// File: rtl/joy_edge_irq.sv
// Interrupt edge detector. It pulses for one cycle after the edge at which
// the nibble first leaves the idle value. Assumes a synchronous active-low reset.
module joy_edge_irq
    import joy_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  grp_t nib_i,
    output logic irq_o
);
    grp_t nib_q;

    // Purpose: remember the last nibble and flag departures from idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nib_q <= IDLE_NIB;
            irq_o <= 1'b0;
        end else begin
            nib_q <= nib_i;
            irq_o <= (nib_q == IDLE_NIB) && (nib_i != IDLE_NIB);
        end
    end
endmodule

// File: rtl/joy_matrix_reg.sv
// Top of the joypad matrix register. It holds the two active-low select bits
// and returns them with the computed nibble. Read data is combinational
// from the stored selects and the live button levels, which are assumed
// debounced and synchronous to clk.
module joy_matrix_reg
    import joy_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int SEL_ACT = 5,
    parameter int SEL_DIR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        act_i,
    input  logic [3:0]        dir_i,
    input  logic [3:0]        mp_id_i,
    input  logic              allow_opp_i,
    input  logic              cs_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    localparam int PAD_W = DATA_W - 2 - GRP_W;

    logic sel_act_q, sel_dir_q;
    grp_t dir_f, nib;
    logic unused_wdata;

    assign unused_wdata = ^{wdata_i[DATA_W-1:SEL_ACT+1], wdata_i[SEL_DIR-1:0]};

    // Purpose: hold the select bits written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_act_q <= 1'b1;
            sel_dir_q <= 1'b1;
        end else if (cs_i && we_i) begin
            sel_act_q <= wdata_i[SEL_ACT];
            sel_dir_q <= wdata_i[SEL_DIR];
        end
    end

    joy_dir_filter u_filt (
        .dir_i   (dir_i),
        .allow_i (allow_opp_i),
        .dir_o   (dir_f)
    );

    joy_nibble u_nib (
        .sel_act_n (sel_act_q),
        .sel_dir_n (sel_dir_q),
        .act_i     (act_i),
        .dir_i     (dir_f),
        .mp_i      (mp_id_i),
        .nib_o     (nib)
    );

    joy_edge_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .nib_i (nib),
        .irq_o (irq_o)
    );

    // Purpose: assemble the read word.
    assign rdata_o = {{PAD_W{1'b1}}, sel_act_q, sel_dir_q, nib};
endmodule

// File: rtl/joy_matrix_reg_chk.sv
// Checker for the joypad matrix register, bound to every instance of the top.
module joy_matrix_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] act_i,
    input logic [3:0] dir_i,
    input logic [3:0] mp_id_i,
    input logic       allow_opp_i,
    input logic       cs_i,
    input logic       we_i,
    input logic [7:0] wdata_i,
    input logic [7:0] rdata_o,
    input logic       irq_o
);
    p_top_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[7:6] == 2'b11);

    p_sel_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_i && we_i) |=> (rdata_o[5:4] == $past(wdata_i[5:4])));

    p_sel_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs_i && we_i) |=> $stable(rdata_o[5:4]));

    p_mp_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_o[5:4] == 2'b11) |-> (rdata_o[3:0] == 4'hF - mp_id_i));

    p_up_masks_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_o[5:4] == 2'b10 && !allow_opp_i && dir_i[2]) |-> rdata_o[3]);

    p_left_masks_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_o[5:4] == 2'b10 && !allow_opp_i && dir_i[1]) |-> rdata_o[0]);

    p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(rdata_o[3:0]) != 4'hF));

    logic unused_chk;
    assign unused_chk = ^{act_i, wdata_i[7:6], wdata_i[3:0]};
endmodule

bind joy_matrix_reg joy_matrix_reg_chk u_chk (.*);

// File: tb/tb_joy_matrix_reg.sv
`timescale 1ns/100ps
module tb_joy_matrix_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] act_i = '0, dir_i = '0, mp_id_i = '0;
    logic       allow_opp_i = 1'b0, cs_i = 1'b0, we_i = 1'b0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;
    logic       irq_o;

    int checks = 0, failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    joy_matrix_reg dut (.*);

    // Vector fields: [22:19] req, [18:17] sel{b5,b4}, [16] allow,
    // [15:12] act, [11:8] dir, [7:4] mp, [3:0] expected nibble
    localparam int NV = 13;
    localparam logic [22:0] VEC [NV] = '{
        {4'd3, 2'b01, 1'b0, 4'b0001, 4'b0000, 4'h0, 4'hE}, // R3 A
        {4'd3, 2'b01, 1'b0, 4'b1000, 4'b0000, 4'h0, 4'h7}, // R3 Start
        {4'd4, 2'b10, 1'b0, 4'b0000, 4'b0001, 4'h0, 4'hE}, // R4 Right
        {4'd4, 2'b10, 1'b0, 4'b0000, 4'b0110, 4'h0, 4'h9}, // R4 Up+Left
        {4'd7, 2'b10, 1'b0, 4'b0000, 4'b1100, 4'h0, 4'hB}, // R7 Up hides Down
        {4'd7, 2'b10, 1'b0, 4'b0000, 4'b0011, 4'h0, 4'hD}, // R7 Left hides Right
        {4'd8, 2'b10, 1'b1, 4'b0000, 4'b1111, 4'h0, 4'h0}, // R8 all shown
        {4'd7, 2'b10, 1'b0, 4'b0000, 4'b1111, 4'h0, 4'h9}, // R7 all masked pairs
        {4'd5, 2'b00, 1'b0, 4'b0001, 4'b1000, 4'h0, 4'h6}, // R5 both groups
        {4'd6, 2'b11, 1'b0, 4'b0000, 4'b0000, 4'h3, 4'hC}, // R6 id 3
        {4'd6, 2'b11, 1'b0, 4'b0000, 4'b0000, 4'h0, 4'hF}, // R6 id 0
        {4'd6, 2'b11, 1'b0, 4'b1111, 4'b1111, 4'h1, 4'hE}, // R6 buttons ignored
        {4'd5, 2'b00, 1'b0, 4'b0000, 4'b0000, 4'h0, 4'hF}  // R5 nothing pressed
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_sel(input logic [1:0] sel, input logic cs);
        @(negedge clk);
        cs_i = cs; we_i = 1'b1; wdata_i = {2'b00, sel, 4'b0000};
        @(negedge clk);
        cs_i = 1'b0; we_i = 1'b0; wdata_i = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset read", rdata_o, 8'hFF);
        chk("R1 reset irq", {7'd0, irq_o}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [22:0] v;
            v = VEC[i];
            allow_opp_i = v[16]; act_i = v[15:12]; dir_i = v[11:8]; mp_id_i = v[7:4];
            wr_sel(v[18:17], 1'b1);
            chk($sformatf("R%0d vec %0d nibble", v[22:19], i), {4'h0, rdata_o[3:0]}, {4'h0, v[3:0]});
            chk($sformatf("R2 vec %0d upper", i), {rdata_o[7:4], 4'h0}, {2'b11, v[18:17], 4'h0});
        end

        // R10: write strobe without chip select is ignored
        act_i = '0; dir_i = '0; mp_id_i = '0; allow_opp_i = 1'b0;
        wr_sel(2'b01, 1'b1);
        wr_sel(2'b10, 1'b0);
        chk("R10 selects kept", {rdata_o[7:4], 4'h0}, 8'hD0);

        // R9: single pulse per departure from idle
        repeat (2) @(negedge clk);
        chk("R9 idle no irq", {7'd0, irq_o}, 8'h00);
        act_i = 4'b0001;
        @(negedge clk);
        chk("R9 pulse on press", {7'd0, irq_o}, 8'h01);
        @(negedge clk);
        chk("R9 pulse ends", {7'd0, irq_o}, 8'h00);
        begin
            int seen;
            seen = 0;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                if (irq_o) seen++;
            end
            chk("R9 no retrigger while held", seen[7:0], 8'h00);
        end
        act_i = 4'b0000;
        repeat (2) @(negedge clk);
        chk("R9 release no irq", {7'd0, irq_o}, 8'h00);
        act_i = 4'b0100;
        @(negedge clk);
        chk("R9 second press pulse", {7'd0, irq_o}, 8'h01);
        act_i = 4'b0000;

        // R1: reset returns selects to 1
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset restores selects", rdata_o, 8'hFF);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule